// File: doc/BRIEF.md
# Serial Result Transmitter, Self-Clocked Burst Mode

This block drives the serial output port of a sampling converter when the port makes its own bit clock. The converter core stores each finished conversion through a load strobe. Each convert strobe then starts a burst that sends that stored word, which is the result of the conversion before the one now starting. The bit clock is made by dividing the system clock. It gives exactly one pulse per bit and sends the most significant bit first. When no burst is running, the bit clock rests low.

The coding is chosen when the burst starts. The core always stores straight binary. With the format input low, the transmitter inverts the top bit, which gives two's complement. Each data bit is set up well before the bit clock rises and is held until after it falls, so a receiver may capture on either edge. When no burst is running, the data line shows the tag input level that was sampled with the convert strobe.

Top module: `serial_result_tx`

## Requirements
- R1: A convert strobe sends the word held by the most recent load strobe before it. A load in the same cycle as the strobe is held for the next burst only.
- R2: Each burst gives exactly WIDTH pulses on `dclk_o`. Between bursts, `dclk_o` stays low.
- R3: Bits are sent most significant first. The least significant bit goes with the last pulse.
- R4: `dout_o` changes only when `dclk_o` is low in that cycle and in the cycle before it. So every bit is stable across both the rising and the falling edge of its pulse.
- R5: Outside a burst, `dout_o` equals the `tag_i` level sampled at the last accepted convert strobe. Changes on `tag_i` at other times have no effect on it.
- R6: If `fmt_sb_i` is 1 at the strobe, the stored word is sent unchanged (straight binary). If it is 0, bit WIDTH-1 is inverted (two's complement). For example, a stored 0xFFFF is sent as 0xFFFF or 0x7FFF, and a stored 0x8000 as 0x8000 or 0x0000.
- R7: The first rising edge of `dclk_o` is seen START_DLY cycles after the clock edge that samples the strobe. After that, the period is 2*HALF cycles, with HALF cycles high and HALF cycles low.
- R8: A convert strobe that arrives during a burst is ignored. The running burst keeps its word, its format and its pulse count.
- R9: After reset, `dclk_o` and `dout_o` are both 0 and no burst is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_i | input | 1 | Convert strobe, one cycle long |
| res_load_i | input | 1 | Stores `res_i` as the latest finished result |
| res_i | input | WIDTH | Finished conversion result, straight binary |
| fmt_sb_i | input | 1 | 1 selects straight binary, 0 selects two's complement |
| tag_i | input | 1 | Level shown on the data line between bursts |
| dclk_o | output | 1 | Burst bit clock |
| dout_o | output | 1 | Serial data |

## Verification
Take edge E0 as the clock edge that samples a strobe. The bench counts falling clock edges after E0:
- the MSB is on `dout_o` one cycle after E0;
- the first pulse rises START_DLY cycles after E0, and the second rises 2*HALF cycles later;
- the line returns to the tag level at START_DLY - HALF/2 + 2*HALF*WIDTH cycles.

The bench checks at exactly those offsets, so a result that comes one cycle early or late fails. The bench captures the bit at each rising edge of `dclk_o` and compares it again at the falling edge. Stimulus that should be ignored is applied at a fixed cycle inside the burst, and its absence of effect is judged from the bits and the idle level seen at the ports.

// File: rtl/serial_result_tx.sv
`timescale 1ns/1ps
module serial_result_tx #(
  parameter int WIDTH     = 16,
  parameter int HALF      = 22,
  parameter int START_DLY = 45
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_i,
  input  logic             res_load_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             fmt_sb_i,
  input  logic             tag_i,
  output logic             dclk_o,
  output logic             dout_o
);
  localparam int QTR  = HALF / 2;
  localparam int LEAD = START_DLY - QTR;
  localparam int SLOT = 2 * HALF;
  localparam int CMAX = (LEAD > SLOT) ? LEAD : SLOT;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int BW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  typedef enum logic [1:0] {IDLE, LEAD_S, SHIFT} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bitn;
  logic [WIDTH-1:0] shreg, hold;
  logic             tag_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold <= '0;
    else if (res_load_i) hold <= res_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      tag_q <= 1'b0;
    end else begin
      case (st)
        IDLE: if (conv_i) begin
          shreg <= {hold[WIDTH-1] ^ ~fmt_sb_i, hold[WIDTH-2:0]};
          tag_q <= tag_i;
          st    <= LEAD_S;
          cnt   <= '0;
          bitn  <= '0;
        end
        LEAD_S: if (cnt == CW'(LEAD - 1)) begin
          st  <= SHIFT;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        SHIFT: if (cnt == CW'(SLOT - 1)) begin
          cnt <= '0;
          if (bitn == BW'(WIDTH - 1)) st <= IDLE;
          else begin
            bitn  <= bitn + 1'b1;
            shreg <= {shreg[WIDTH-2:0], 1'b0};
          end
        end else cnt <= cnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  assign dclk_o = (st == SHIFT) && (cnt >= CW'(QTR)) && (cnt < CW'(QTR + HALF));
  assign dout_o = (st == IDLE) ? tag_q : shreg[WIDTH-1];
endmodule

module serial_result_tx_chk #(
  parameter int WIDTH = 16,
  parameter int HALF  = 22
) (
  input logic clk,
  input logic rst_n,
  input logic dclk_o,
  input logic dout_o
);
  logic [15:0] hi_cnt, lo_cnt;
  logic [7:0]  pcnt;
  logic        d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= 16'hFFFF;
      pcnt   <= '0;
      d_q    <= 1'b0;
    end else begin
      d_q    <= dclk_o;
      hi_cnt <= dclk_o ? hi_cnt + 16'd1 : 16'd0;
      lo_cnt <= dclk_o ? 16'd0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1);
      if (dclk_o && !d_q) pcnt <= (lo_cnt > 16'(HALF)) ? 8'd1 : pcnt + 8'd1;
    end
  end

  // R4
  dout_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_o) |-> (!dclk_o && !$past(dclk_o)));

  // R7
  hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_o |-> (hi_cnt < 16'(HALF)));

  // R7
  fall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dclk_o) |-> (hi_cnt == 16'(HALF)));

  // R7
  rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_o) |-> (lo_cnt >= 16'(HALF)));

  // R2
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dclk_o) && (lo_cnt <= 16'(HALF))) |-> (pcnt < 8'(WIDTH)));
endmodule

bind serial_result_tx serial_result_tx_chk #(.WIDTH(WIDTH), .HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .dclk_o(dclk_o), .dout_o(dout_o));

// File: tb/tb_serial_result_tx.sv
`timescale 1ns/1ps
module tb_serial_result_tx;
  localparam int W = 16, H = 22, SD = 45, Q = H / 2;
  localparam int ENDC = SD - Q + 2 * H * W;

  logic clk = 0, rst_n = 0, conv_i = 0, res_load_i = 0, fmt_sb_i = 1, tag_i = 0;
  logic [W-1:0] res_i = '0;
  logic dclk_o, dout_o;
  int checks = 0, errors = 0;
  bit done = 0;

  // load word, format, tag, expected serial word
  localparam logic [33:0] VEC [7] = '{
    {16'hFFFF, 1'b1, 1'b1, 16'hFFFF},
    {16'hFFFF, 1'b0, 1'b0, 16'h7FFF},
    {16'h8000, 1'b0, 1'b1, 16'h0000},
    {16'h8000, 1'b1, 1'b0, 16'h8000},
    {16'h0000, 1'b0, 1'b1, 16'h8000},
    {16'hA5C3, 1'b1, 1'b0, 16'hA5C3},
    {16'h1234, 1'b0, 1'b1, 16'h9234}
  };

  serial_result_tx #(.WIDTH(W), .HALF(H), .START_DLY(SD)) dut (
    .clk(clk), .rst_n(rst_n), .conv_i(conv_i), .res_load_i(res_load_i), .res_i(res_i),
    .fmt_sb_i(fmt_sb_i), .tag_i(tag_i), .dclk_o(dclk_o), .dout_o(dout_o));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [W-1:0] w);
    @(negedge clk); res_load_i = 1; res_i = w;
    @(negedge clk); res_load_i = 0;
  endtask

  task automatic run_burst(input logic [W-1:0] exp, input logic tag_exp, input bit ld,
                           input logic [W-1:0] ldw, input bit mid, input logic [W-1:0] midw,
                           input logic midfmt, input string req);
    int first = -1, second = -1, pulses = 0, bad = 0;
    logic [W-1:0] got = '0;
    logic pd = 0, po = 0, lowend = 1;
    @(negedge clk); conv_i = 1;
    if (ld) begin res_load_i = 1; res_i = ldw; end
    @(negedge clk); conv_i = 0; res_load_i = 0;
    for (int m = 0; m <= ENDC + 2; m++) begin
      if (dclk_o && !pd) begin
        pulses++; got = {got[W-2:0], dout_o};
        if (first < 0) first = m; else if (second < 0) second = m;
      end
      if (!dclk_o && pd && dout_o !== got[0]) bad++;
      if (dclk_o && pd && dout_o !== po) bad++;
      if (m >= ENDC && dclk_o) lowend = 0;
      if (m == ENDC) chk(dout_o === tag_exp, "R5 idle level after burst", 32'(dout_o), 32'(tag_exp));
      if (mid && m == 100) begin conv_i = 1; res_load_i = 1; res_i = midw; fmt_sb_i = midfmt; end
      if (mid && m == 101) begin conv_i = 0; res_load_i = 0; end
      pd = dclk_o; po = dout_o;
      @(negedge clk);
    end
    chk(first == SD, "R7 first rise delay", 32'(first), 32'(SD));
    chk(second == SD + 2 * H, "R7 bit clock period", 32'(second), 32'(SD + 2 * H));
    chk(pulses == W, "R2 R8 pulse count", 32'(pulses), 32'(W));
    chk(got === exp, req, 32'(got), 32'(exp));
    chk(bad == 0, "R4 data stable on both edges", 32'(bad), 32'd0);
    chk(lowend, "R2 clock low after burst", 32'(!lowend), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dclk_o === 1'b0, "R9 reset clock", 32'(dclk_o), 32'd0);
    chk(dout_o === 1'b0, "R9 reset data", 32'(dout_o), 32'd0);
    rst_n = 1;
    repeat (50) @(negedge clk);
    chk(dclk_o === 1'b0 && dout_o === 1'b0, "R9 idle after reset", {30'd0, dclk_o, dout_o}, 32'd0);

    for (int i = 0; i < 7; i++) begin
      load(VEC[i][33:18]);
      fmt_sb_i = VEC[i][17];
      tag_i    = VEC[i][16];
      run_burst(VEC[i][15:0], VEC[i][16], 0, '0, 0, '0, 1'b0, "R3 R6 table word");
    end

    load(16'h1111); fmt_sb_i = 1; tag_i = 0;
    run_burst(16'h1111, 1'b0, 0, '0, 1, 16'h2222, 1'b0, "R1 R8 word kept mid-burst");
    tag_i = 1;
    run_burst(16'hA222, 1'b1, 0, '0, 0, '0, 1'b0, "R1 R6 next burst word");
    tag_i = 0;
    repeat (10) @(negedge clk);
    chk(dout_o === 1'b1, "R5 tag change ignored when idle", 32'(dout_o), 32'd1);
    fmt_sb_i = 1;
    run_burst(16'h2222, 1'b0, 1, 16'h3333, 0, '0, 1'b0, "R1 same-cycle load deferred");
    run_burst(16'h3333, 1'b0, 0, '0, 0, '0, 1'b0, "R1 deferred word sent");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule